// File: doc/BRIEF.md
# Receive Ring Start-of-Packet Scanner

When receive descriptors are handed out ahead of time, the host may give a packet more buffers than it needs. Once the last buffer of a packet has been closed, the controller has to find the descriptor where the next packet starts. This block walks the receive ring, one entry at a time, from the entry after the last one the previous packet used. It reads each entry's ownership and start-of-packet flags, and it stops at the first entry whose start-of-packet flag is set. That entry's buffer is where the next packet's data will go. Buffers that follow it without the flag may take the middle of a packet later on.

The scan does not stop at entries the host owns. A controller-owned entry that is not a packet start is returned to the host through a write-back that clears its ownership bit. The block waits for that write to be acknowledged before it reads anything else. A host-owned entry that is not a packet start is skipped and left unchanged. When the start entry itself belongs to the host, the block reports that and keeps the index, so the entry can be polled again later. If a whole lap of the ring passes without a start entry, the scan ends with an error flag. Descriptor reads and writes are done by an outside agent through simple request/response handshakes.

Top module: `rx_sop_finder`

## Requirements
- R1: An accepted start command with last-used index L makes the first entry read L+1. When L is RING_LEN-1, the first entry read is entry 0.
- R2: Each entry read holds rd_req_o high with a stable rd_idx_o until rd_valid_i arrives. The next read goes to the following index, which wraps from RING_LEN-1 to 0.
- R3: A read response with rd_own_i=1 and rd_sop_i=0 (1 means controller-owned and packet start) raises wb_req_o, which means "write ownership 0", for that same index. wb_req_o stays high until wb_ack_i. No read is issued while it is pending, and the scan then goes on to the next index.
- R4: A response with rd_own_i=0 and rd_sop_i=0 causes no write-back. The scan moves straight to the next index.
- R5: A response with rd_sop_i=1 ends the scan. done_o pulses in the cycle after that response, and found_idx_o then equals the index of that entry.
- R6: not_owned_o equals the inverse of the found entry's ownership flag. found_idx_o, not_owned_o and lap_err_o keep their values until the next scan completes.
- R7: When RING_LEN entries have been examined and none is a packet start, done_o pulses with lap_err_o=1 and not_owned_o=0, and no further entry is read.
- R8: start_i is ignored while a scan is in progress (busy_o=1).
- R9: After reset, busy_o, rd_req_o, wb_req_o, done_o, not_owned_o and lap_err_o are 0.
- R10: busy_o is 1 from the cycle after an accepted start until done_o. done_o lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (accepted only when idle) |
| last_idx_i | input | IDX_W | Index of the last descriptor used by the previous packet |
| busy_o | output | 1 | Scan in progress |
| rd_req_o | output | 1 | Request to read the descriptor flags at rd_idx_o |
| rd_idx_o | output | IDX_W | Ring index to read |
| rd_valid_i | input | 1 | Read response valid (one cycle) |
| rd_own_i | input | 1 | Response ownership flag, 1 = controller-owned |
| rd_sop_i | input | 1 | Response start-of-packet flag |
| wb_req_o | output | 1 | Request to clear the ownership bit at wb_idx_o |
| wb_idx_o | output | IDX_W | Ring index to write back |
| wb_ack_i | input | 1 | Write-back completed (one cycle) |
| done_o | output | 1 | One-cycle pulse when the scan ends |
| found_idx_o | output | IDX_W | Index of the start entry found |
| not_owned_o | output | 1 | Found start entry is host-owned |
| lap_err_o | output | 1 | Scan covered a full lap without a start entry |

## Verification
A wrong current-index or state register shows up at the ports on the next read or write-back request. The index would not be the one that follows the previous entry, or a read would appear while a write-back is still unacknowledged. Either mismatch is visible within one cycle of the faulty transition. A lap counter that is off by one shows only at the end of a scan without a start entry. It then gives one read too many or too few, or a start entry at the final position reported as an error. The scenarios place the start entry on the last entry of the lap to expose this. A fault in the result registers shows when done_o pulses, or in the idle cycles that follow it.

// File: rtl/rx_sop_pkg.sv
package rx_sop_pkg;

    // Scanner control states
    typedef enum logic [1:0] {
        SOP_IDLE  = 2'd0,
        SOP_READ  = 2'd1,
        SOP_CLEAR = 2'd2
    } sop_state_e;

endpackage

// File: rtl/rx_sop_ring_step.sv
// Combinational ring successor: idx + 1, wrapping at RING_LEN.
module rx_sop_ring_step #(
    parameter int RING_LEN = 16,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] next_o
);
    generate
        if (RING_LEN == 1) begin : g_single
            assign next_o = '0;
        end else if ((RING_LEN & (RING_LEN - 1)) == 0 && (1 << IDX_W) == RING_LEN) begin : g_pow2
            // Natural overflow of the index gives the wrap.
            assign next_o = idx_i + 1'b1;
        end else begin : g_cmp
            localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);
            assign next_o = (idx_i == LAST_IDX) ? '0 : idx_i + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rx_sop_lap_track.sv
// Counts entries examined in the current scan; flags the final entry of a lap.
module rx_sop_lap_track #(
    parameter int RING_LEN = 16,
    parameter int IDX_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam logic [IDX_W-1:0] FINAL_CNT = IDX_W'(RING_LEN - 1);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == FINAL_CNT);
endmodule

// File: rtl/rx_sop_finder.sv
module rx_sop_finder
    import rx_sop_pkg::*;
#(
    parameter int RING_LEN = 16,
    localparam int IDX_W   = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic             busy_o,
    output logic             rd_req_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic             rd_valid_i,
    input  logic             rd_own_i,
    input  logic             rd_sop_i,
    output logic             wb_req_o,
    output logic [IDX_W-1:0] wb_idx_o,
    input  logic             wb_ack_i,
    output logic             done_o,
    output logic [IDX_W-1:0] found_idx_o,
    output logic             not_owned_o,
    output logic             lap_err_o
);

    typedef struct packed {
        sop_state_e       state;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] found;
        logic             not_owned;
        logic             lap_err;
        logic             done;
    } scan_regs_t;

    scan_regs_t r_d, r_q;

    logic [IDX_W-1:0] first_idx;
    logic [IDX_W-1:0] succ_idx;
    logic             lap_last;
    logic             advance;
    logic             launch;

    // Successor of the last-used entry: first entry to examine.
    rx_sop_ring_step #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_first_step (
        .idx_i  (last_idx_i),
        .next_o (first_idx)
    );

    // Successor of the entry under examination.
    rx_sop_ring_step #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_cur_step (
        .idx_i  (r_q.cur),
        .next_o (succ_idx)
    );

    rx_sop_lap_track #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_lap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .step_i  (advance),
        .last_o  (lap_last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        advance = 1'b0;
        launch  = 1'b0;

        unique case (r_q.state)
            SOP_IDLE: begin
                if (start_i) begin
                    launch    = 1'b1;
                    r_d.state = SOP_READ;
                    r_d.cur   = first_idx;
                end
            end
            SOP_READ: begin
                if (rd_valid_i) begin
                    if (rd_sop_i) begin
                        r_d.state     = SOP_IDLE;
                        r_d.done      = 1'b1;
                        r_d.found     = r_q.cur;
                        r_d.not_owned = ~rd_own_i;
                        r_d.lap_err   = 1'b0;
                    end else if (rd_own_i) begin
                        // Hand the entry back before looking further.
                        r_d.state = SOP_CLEAR;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            SOP_CLEAR: begin
                if (wb_ack_i) begin
                    advance = 1'b1;
                end
            end
            default: begin
                r_d.state = SOP_IDLE;
            end
        endcase

        if (advance) begin
            if (lap_last) begin
                r_d.state     = SOP_IDLE;
                r_d.done      = 1'b1;
                r_d.found     = r_q.cur;
                r_d.not_owned = 1'b0;
                r_d.lap_err   = 1'b1;
            end else begin
                r_d.state = SOP_READ;
                r_d.cur   = succ_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= SOP_IDLE;
            r_q.cur       <= '0;
            r_q.found     <= '0;
            r_q.not_owned <= 1'b0;
            r_q.lap_err   <= 1'b0;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.state != SOP_IDLE);
    assign rd_req_o    = (r_q.state == SOP_READ);
    assign rd_idx_o    = r_q.cur;
    assign wb_req_o    = (r_q.state == SOP_CLEAR);
    assign wb_idx_o    = r_q.cur;
    assign done_o      = r_q.done;
    assign found_idx_o = r_q.found;
    assign not_owned_o = r_q.not_owned;
    assign lap_err_o   = r_q.lap_err;

endmodule

// File: rtl/rx_sop_finder_chk.sv
module rx_sop_finder_chk #(
    parameter int RING_LEN = 16,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             rd_req_o,
    input logic [IDX_W-1:0] rd_idx_o,
    input logic             rd_valid_i,
    input logic             rd_own_i,
    input logic             rd_sop_i,
    input logic             wb_req_o,
    input logic [IDX_W-1:0] wb_idx_o,
    input logic             wb_ack_i,
    input logic             done_o,
    input logic [IDX_W-1:0] found_idx_o,
    input logic             not_owned_o,
    input logic             lap_err_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RING_LEN - 1);

    logic [IDX_W-1:0] rd_after, wb_after;
    assign rd_after = (rd_idx_o == TOP_IDX) ? '0 : IDX_W'(rd_idx_o + 1'b1);
    assign wb_after = (wb_idx_o == TOP_IDX) ? '0 : IDX_W'(wb_idx_o + 1'b1);

    // R3: a read and a write-back are never requested together
    p_rd_wb_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wb_req_o));

    // R2: a pending read keeps its index
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_idx_o));

    // R3: a pending write-back keeps its index
    p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_idx_o));

    // R3: controller-owned non-start entry is written back
    p_own_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_valid_i && rd_own_i && !rd_sop_i
        |=> wb_req_o && wb_idx_o == $past(rd_idx_o));

    // R4: host-owned non-start entry moves to the successor without a write
    p_host_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_valid_i && !rd_own_i && !rd_sop_i
        |=> !wb_req_o && ((rd_req_o && rd_idx_o == $past(rd_after)) || done_o));

    // R2: after a write-back the scan continues at the successor
    p_wb_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o && wb_ack_i
        |=> (rd_req_o && rd_idx_o == $past(wb_after)) || done_o);

    // R5, R6: start entry ends the scan and reports its index and owner
    p_sop_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_valid_i && rd_sop_i
        |=> done_o && !busy_o && found_idx_o == $past(rd_idx_o)
            && not_owned_o == !$past(rd_own_i) && !lap_err_o);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: results hold while idle and no start arrives
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i
        |=> $stable(found_idx_o) && $stable(not_owned_o) && $stable(lap_err_o));

    // R7: a lap error never reports a host-owned start
    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lap_err_o |-> !not_owned_o);

    // R9: no requests while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !wb_req_o);

endmodule

bind rx_sop_finder rx_sop_finder_chk #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .rd_req_o    (rd_req_o),
    .rd_idx_o    (rd_idx_o),
    .rd_valid_i  (rd_valid_i),
    .rd_own_i    (rd_own_i),
    .rd_sop_i    (rd_sop_i),
    .wb_req_o    (wb_req_o),
    .wb_idx_o    (wb_idx_o),
    .wb_ack_i    (wb_ack_i),
    .done_o      (done_o),
    .found_idx_o (found_idx_o),
    .not_owned_o (not_owned_o),
    .lap_err_o   (lap_err_o)
);

// File: tb/rx_sop_finder_tb.sv
module rx_sop_finder_tb;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [IW-1:0] last_idx_i = '0;
    logic          busy_o, rd_req_o, wb_req_o, done_o, not_owned_o, lap_err_o;
    logic [IW-1:0] rd_idx_o, wb_idx_o, found_idx_o;
    logic          rd_valid_i = 1'b0, rd_own_i = 1'b0, rd_sop_i = 1'b0, wb_ack_i = 1'b0;

    always #2.5 clk = ~clk;

    rx_sop_finder #(.RING_LEN(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_idx_i(last_idx_i),
        .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o),
        .rd_valid_i(rd_valid_i), .rd_own_i(rd_own_i), .rd_sop_i(rd_sop_i),
        .wb_req_o(wb_req_o), .wb_idx_o(wb_idx_o), .wb_ack_i(wb_ack_i),
        .done_o(done_o), .found_idx_o(found_idx_o),
        .not_owned_o(not_owned_o), .lap_err_o(lap_err_o)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  own_m [N];
    bit  sop_m [N];
    int  exp_rd_q[$];
    int  exp_wb_q[$];
    int  lat = 0;
    bit  responder_on = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Descriptor agent with a behavioural ring; compared every clock.
    initial begin : responder
        int rd_wait = 0;
        int wb_wait = 0;
        forever begin
            @(negedge clk);
            rd_valid_i = 1'b0;
            wb_ack_i   = 1'b0;
            if (responder_on) begin
                if (rd_req_o && wb_req_o) chk(0, "R3", "read and write-back together", 1, 0);
                if (rd_req_o) begin
                    if (rd_wait >= lat) begin
                        if (exp_rd_q.size() == 0) begin
                            chk(0, "R2", "unexpected read index", int'(rd_idx_o), -1);
                        end else begin
                            chk(int'(rd_idx_o) == exp_rd_q[0], "R2", "read index",
                                int'(rd_idx_o), exp_rd_q[0]);
                            void'(exp_rd_q.pop_front());
                        end
                        rd_own_i   = own_m[rd_idx_o];
                        rd_sop_i   = sop_m[rd_idx_o];
                        rd_valid_i = 1'b1;
                        rd_wait    = 0;
                    end else begin
                        rd_wait++;
                    end
                end
                if (wb_req_o) begin
                    if (wb_wait >= lat) begin
                        if (exp_wb_q.size() == 0) begin
                            chk(0, "R4", "unexpected write-back", int'(wb_idx_o), -1);
                        end else begin
                            chk(int'(wb_idx_o) == exp_wb_q[0], "R3", "write-back index",
                                int'(wb_idx_o), exp_wb_q[0]);
                            void'(exp_wb_q.pop_front());
                        end
                        own_m[wb_idx_o] = 1'b0;
                        wb_ack_i = 1'b1;
                        wb_wait  = 0;
                    end else begin
                        wb_wait++;
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic load_ring(logic [N-1:0] own_v, logic [N-1:0] sop_v);
        for (int i = 0; i < N; i++) begin
            own_m[i] = own_v[i];
            sop_m[i] = sop_v[i];
        end
    endtask

    // One scan: build expectations from the ring, run, compare.
    task automatic run_scan(int last, int latency, bit poke, string tag);
        int  idx;
        int  e_found = 0;
        bit  e_no = 1'b0;
        bit  e_err = 1'b1;
        bit  e_own [N];
        int  t = 0;
        exp_rd_q.delete();
        exp_wb_q.delete();
        for (int i = 0; i < N; i++) e_own[i] = own_m[i];
        idx = (last + 1) % N;
        for (int k = 0; k < N; k++) begin
            exp_rd_q.push_back(idx);
            if (sop_m[idx]) begin
                e_found = idx; e_no = !own_m[idx]; e_err = 1'b0;
                break;
            end
            if (own_m[idx]) begin
                exp_wb_q.push_back(idx);
                e_own[idx] = 1'b0;
            end
            idx = (idx + 1) % N;
        end
        lat = latency;
        responder_on = 1'b1;
        start_i    = 1'b1;
        last_idx_i = IW'(last);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", {tag, " busy after start"}, int'(busy_o), 1);
        while (!done_o && t < 400) begin
            @(negedge clk);
            t++;
            if (poke && t == 2) begin
                chk(busy_o == 1'b1, "R8", {tag, " busy before extra start"}, int'(busy_o), 1);
                start_i    = 1'b1;
                last_idx_i = IW'((last + 3) % N);
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R10", {tag, " done seen"}, int'(done_o), 1);
        chk(exp_rd_q.size() == 0, "R2", {tag, " reads left over"}, exp_rd_q.size(), 0);
        chk(exp_wb_q.size() == 0, "R3", {tag, " write-backs left over"}, exp_wb_q.size(), 0);
        chk(lap_err_o == e_err, "R7", {tag, " lap error"}, int'(lap_err_o), int'(e_err));
        if (!e_err) begin
            chk(int'(found_idx_o) == e_found, "R5", {tag, " found index"}, int'(found_idx_o), e_found);
            chk(not_owned_o == e_no, "R6", {tag, " not-owned"}, int'(not_owned_o), int'(e_no));
        end else begin
            chk(not_owned_o == 1'b0, "R7", {tag, " not-owned on error"}, int'(not_owned_o), 0);
        end
        for (int i = 0; i < N; i++)
            chk(own_m[i] == e_own[i], "R4", {tag, " ring ownership after scan"}, int'(own_m[i]), int'(e_own[i]));
        @(negedge clk);
        chk(done_o == 1'b0, "R10", {tag, " done one cycle"}, int'(done_o), 0);
        chk(busy_o == 1'b0, "R10", {tag, " idle after done"}, int'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk(lap_err_o == e_err, "R6", {tag, " lap flag held"}, int'(lap_err_o), int'(e_err));
        if (!e_err) begin
            chk(int'(found_idx_o) == e_found, "R6", {tag, " index held"}, int'(found_idx_o), e_found);
            chk(not_owned_o == e_no, "R6", {tag, " not-owned held"}, int'(not_owned_o), int'(e_no));
        end
        chk(!rd_req_o && !wb_req_o, "R9", {tag, " quiet while idle"}, int'(rd_req_o | wb_req_o), 0);
    endtask

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy_o == 1'b0, "R9", "busy in reset", int'(busy_o), 0);
        chk(rd_req_o == 1'b0 && wb_req_o == 1'b0, "R9", "requests in reset", int'(rd_req_o | wb_req_o), 0);
        chk(done_o == 1'b0, "R9", "done in reset", int'(done_o), 0);
        chk(not_owned_o == 1'b0 && lap_err_o == 1'b0, "R9", "flags in reset",
            int'(not_owned_o | lap_err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R3, R4, R5: owned skip, host skip, owned start
        load_ring(8'h28, 8'h20);
        run_scan(2, 0, 1'b0, "mixed");
        // R2, R3, R6: write-backs across the wrap, host-owned start
        load_ring(8'h81, 8'h02);
        run_scan(6, 1, 1'b0, "wrap");
        // R1: last index at ring top starts at entry 0
        load_ring(8'h01, 8'h01);
        run_scan(7, 0, 1'b0, "top");
        // R7: no start entry anywhere
        load_ring(8'h5A, 8'h00);
        run_scan(4, 2, 1'b0, "lap");
        // R8: extra start while busy is ignored
        load_ring(8'h7E, 8'h40);
        run_scan(0, 3, 1'b1, "poke");
        // R7 boundary: start entry is the final entry of the lap
        load_ring(8'h00, 8'h08);
        run_scan(3, 0, 1'b0, "edge");
        // R5: start right after the last-used entry, slow agent
        load_ring(8'hF0, 8'h11);
        run_scan(3, 4, 1'b0, "near");

        finish_run();
    end
endmodule